// File: doc/BRIEF.md
# Programmable Pulse-Reset Frequency Divider

This block divides an input clock by an integer N chosen when the block is reset. A binary counter steps on every falling edge of the clock. A pulse stage, clocked on the rising edge, watches the count. When the end of a cycle is detected it raises a pulse, and that pulse clears the counter at the next falling edge. The block therefore emits one pulse for every N input clocks, and no compare-and-reload path is involved.

Two ways of forming the clearing pulse can be selected. In the pre-count scheme (mode 0), a decoder flags the count N-1 and a D flip-flop captures the flag. In the latched scheme (mode 1), a decoder watches the counter's increment bus for the value N and sets a set/reset flag, and a zero decoder releases that flag once the counter reads zero. Each scheme gives two outputs. One is a pulse one full clock period wide. The other is a half-period pulse, present only while the clock is low inside that period. A divisor below 2 cannot be used: the block raises an error flag and stays quiet.

Top module: `divn_top`

## Requirements
- R1: While rst_n is low at clock edges, count_o is 0 and both pulse outputs are 0. div_n_i and mode_i are captured at each falling edge during reset.
- R2: After reset is released, count_o increases by one at each falling clock edge, starting from 0.
- R3: count_o runs through 0..N-1. It returns to 0 at the falling edge that falls inside a full-width pulse.
- R4: pulse_full_o rises at the rising edge where count_o equals N-1 and stays high for exactly one clock period. Successive rises are exactly N clocks apart.
- R5: pulse_short_o is high only during the low half of the clock period in which pulse_full_o is high. It is 0 at all other times.
- R6: mode 0 (pre-count D flip-flop) and mode 1 (increment-bus decode of N, with a flag held until the count reads zero) both give the output timing of R2-R5.
- R7: A captured divisor of 0 or 1 sets err_o to 1, holds count_o at 0 and keeps both pulses at 0. A legal divisor gives err_o = 0.
- R8: The largest divisor, 2^W (4096 at the default W = 12), divides correctly.
- R9: A change of div_n_i or mode_i after reset release has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset; divisor and mode are captured while it is low |
| div_n_i | input | W+1 | Divisor N, legal from 2 to 2^W |
| mode_i | input | 1 | 0 = pre-count flip-flop scheme, 1 = latched zero-release scheme |
| count_o | output | W | Current counter value |
| pulse_short_o | output | 1 | Half-period pulse in the low phase of the pulse period |
| pulse_full_o | output | 1 | One-clock-period pulse, once per N clocks |
| err_o | output | 1 | Captured divisor is illegal (below 2) |

## Verification
The count changes at each falling edge. The full pulse changes one rising edge after the count reaches N-1. The short pulse follows the clock's low phase within that same period. The bench therefore samples twice per clock: 5 ns after each falling edge, where the count, the short pulse and the just-begun low phase are due, and 5 ns after each rising edge, where the newly captured pulse state is due. A behavioural model indexes falling edges since release. It predicts count = k mod N, a full pulse in the high phase when k mod N = N-1, and a full and short pulse in the low phase when k mod N = 0. The spacing between rising pulse edges is also measured against N.

// File: rtl/divn_pkg.sv
`timescale 1ns/1ps
// Package divn_pkg: shared type for the divider's pulse-forming scheme selection.
// Assumes: one mode bit, captured at reset.
package divn_pkg;
    typedef enum logic {
        SCHEME_PRECOUNT = 1'b0,
        SCHEME_LATCHED  = 1'b1
    } scheme_e;
endpackage

// File: rtl/divn_counter.sv
`timescale 1ns/1ps
// Module divn_counter: falling-edge binary counter with a clearing input.
// It also holds the divisor and mode registers, which are loaded only while reset is low.
// Assumes: clear comes from a rising-edge register, so it is stable at the falling edge.
module divn_counter
    import divn_pkg::*;
#(
    parameter int W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W:0]    div_in,
    input  logic          mode_in,
    input  logic          clear,
    output logic [W-1:0]  cnt,
    output logic [W:0]    div_q,
    output scheme_e       mode_q,
    output logic          illegal
);
    localparam int DW = W + 1;
    localparam logic [DW-1:0] MIN_DIV = DW'(2);

    // Capture divisor and mode only during reset.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            div_q  <= div_in;
            mode_q <= scheme_e'(mode_in);
        end
    end

    // Divisors below the minimum are flagged as illegal.
    assign illegal = (div_q < MIN_DIV);

    // Step the count on each falling edge; reset, an illegal divisor or a pulse clears it.
    always_ff @(negedge clk) begin
        if (!rst_n || illegal || clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/divn_decode.sv
`timescale 1ns/1ps
// Module divn_decode: count decoders for both schemes.
//   hit_pre  - the count equals N-1 (pre-count scheme)
//   hit_next - the counter's increment bus equals N (latched scheme)
//   zero     - the count reads all zeros (releases the latched flag)
// Assumes: div_q is static outside reset.
module divn_decode #(
    parameter int W = 12
) (
    input  logic [W-1:0] cnt,
    input  logic [W:0]   div_q,
    output logic         hit_pre,
    output logic         hit_next,
    output logic         zero
);
    localparam int DW = W + 1;
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] cnt_ext;
    logic [DW-1:0] inc_bus;
    logic [DW-1:0] div_m1;
    logic [W-1:0]  zero_bits;

    // Widen the count so that N = 2^W compares without overflow.
    assign cnt_ext = {1'b0, cnt};
    assign inc_bus = cnt_ext + ONE;
    assign div_m1  = div_q - ONE;

    // Terminal-count decoders.
    assign hit_pre  = (cnt_ext == div_m1);
    assign hit_next = (inc_bus == div_q);

    // Per-bit zero detect, reduced with an AND.
    for (genvar b = 0; b < W; b++) begin : g_zero
        assign zero_bits[b] = ~cnt[b];
    end
    assign zero = &zero_bits;
endmodule

// File: rtl/divn_pulse.sv
`timescale 1ns/1ps
// Module divn_pulse: rising-edge pulse stage.
// The D flip-flop serves the pre-count scheme and the set/reset flag serves the latched
// scheme; the captured mode picks the active one. The short pulse gates the full pulse
// with the clock's low phase.
// Assumes: the decoder inputs settle after falling edges, half a period before capture.
module divn_pulse
    import divn_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  scheme_e mode_q,
    input  logic    illegal,
    input  logic    hit_pre,
    input  logic    hit_next,
    input  logic    zero,
    output logic    pulse_full,
    output logic    pulse_short
);
    logic pre_q;
    logic sr_q;

    // Pre-count scheme: register the N-1 decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= 1'b0;
        end else begin
            pre_q <= hit_pre & ~illegal;
        end
    end

    // Latched scheme: set on an N decode, hold, release when the count reads zero.
    always_ff @(posedge clk) begin
        if (!rst_n || illegal) begin
            sr_q <= 1'b0;
        end else if (hit_next) begin
            sr_q <= 1'b1;
        end else if (zero) begin
            sr_q <= 1'b0;
        end
    end

    // Select the active scheme's pulse source.
    assign pulse_full  = (mode_q == SCHEME_LATCHED) ? sr_q : pre_q;

    // Half-period pulse: the full pulse qualified by the low clock phase.
    assign pulse_short = pulse_full & ~clk;
endmodule

// File: rtl/divn_top.sv
`timescale 1ns/1ps
// Module divn_top: divide-by-N with pulse reset.
// A falling-edge counter and a rising-edge pulse stage form a loop: decode, capture,
// clear. The loop gives one pulse per N clocks for 2 <= N <= 2^W.
// Assumes: divisor and mode change only while rst_n is low.
module divn_top
    import divn_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W:0]   div_n_i,
    input  logic         mode_i,
    output logic [W-1:0] count_o,
    output logic         pulse_short_o,
    output logic         pulse_full_o,
    output logic         err_o
);
    logic [W:0] div_q;
    scheme_e    mode_q;
    logic       illegal;
    logic       hit_pre;
    logic       hit_next;
    logic       zero;
    logic       full_w;
    logic       short_w;

    // Falling-edge counter and configuration registers.
    divn_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_in  (div_n_i),
        .mode_in (mode_i),
        .clear   (full_w),
        .cnt     (count_o),
        .div_q   (div_q),
        .mode_q  (mode_q),
        .illegal (illegal)
    );

    // Terminal and zero decoders.
    divn_decode #(.W(W)) u_dec (
        .cnt      (count_o),
        .div_q    (div_q),
        .hit_pre  (hit_pre),
        .hit_next (hit_next),
        .zero     (zero)
    );

    // Rising-edge pulse stage.
    divn_pulse u_pls (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_q      (mode_q),
        .illegal     (illegal),
        .hit_pre     (hit_pre),
        .hit_next    (hit_next),
        .zero        (zero),
        .pulse_full  (full_w),
        .pulse_short (short_w)
    );

    // Drive the outputs.
    assign pulse_full_o  = full_w;
    assign pulse_short_o = short_w;
    assign err_o         = illegal;
endmodule

// File: rtl/divn_checker.sv
`timescale 1ns/1ps
// Module divn_checker: temporal properties of divn_top, attached with bind.
module divn_checker #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] count,
    input logic         full,
    input logic         short_p,
    input logic         err,
    input logic [W:0]   div
);
    AST_CLEAR_AFTER_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
        full |=> (count == '0)) else $error("clear"); // R3

    AST_DETECT_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && ({1'b0, count} == div - 1'b1)) |=> full) else $error("detect"); // R4

    AST_PULSE_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> !full) else $error("width"); // R4

    AST_SHORT_HIGH_PHASE_LOW: assert property (@(negedge clk) disable iff (!rst_n)
        !short_p) else $error("short"); // R5

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (count == '0 && !full)) else $error("err"); // R7

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> ({1'b0, count} < div)) else $error("range"); // R3
endmodule

bind divn_top divn_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count_o),
    .full    (pulse_full_o),
    .short_p (pulse_short_o),
    .err     (err_o),
    .div     (div_q)
);

// File: tb/tb_divn_top.sv
`timescale 1ns/1ps
module tb_divn_top;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W:0]   div_n_i = 13'd4;
    logic         mode_i = 1'b0;
    logic [W-1:0] count_o;
    logic         pulse_short_o;
    logic         pulse_full_o;
    logic         err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    divn_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .div_n_i(div_n_i), .mode_i(mode_i),
        .count_o(count_o), .pulse_short_o(pulse_short_o),
        .pulse_full_o(pulse_full_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reset with the given divisor and mode, then check the reset state.
    task automatic do_reset(input int n, input bit m);
        @(posedge clk); #2;
        rst_n = 1'b0; div_n_i = (W+1)'(n); mode_i = m;
        repeat (3) @(negedge clk);
        #5;
        chk(count_o == '0, "R1", "reset count", int'(count_o), 0);
        chk(pulse_full_o == 1'b0, "R1", "reset full", int'(pulse_full_o), 0);
        chk(pulse_short_o == 1'b0, "R1", "reset short", int'(pulse_short_o), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
    endtask

    // Run a legal divisor and compare with the model at every half period.
    task automatic run_div(input int n, input bit m, input int cyc, input string req,
                           input bit disturb);
        int last_rise = -1;
        do_reset(n, m);
        if (disturb) begin
            div_n_i = (W+1)'(n + 3); // R9: must be ignored
            mode_i  = ~m;
        end
        for (int k = 1; k <= cyc; k++) begin
            int ph = k % n;
            @(negedge clk); #5;
            chk(int'(count_o) == ph, req, "count (R2 R3)", int'(count_o), ph);
            chk(pulse_full_o == (ph == 0), req, "low-phase full (R4)", int'(pulse_full_o), int'(ph == 0));
            chk(pulse_short_o == (ph == 0), req, "short (R5)", int'(pulse_short_o), int'(ph == 0));
            chk(err_o == 1'b0, req, "err legal (R7)", int'(err_o), 0);
            @(posedge clk); #5;
            chk(pulse_full_o == (ph == n - 1), req, "high-phase full (R4)", int'(pulse_full_o), int'(ph == n - 1));
            chk(pulse_short_o == 1'b0, req, "short high phase (R5)", int'(pulse_short_o), 0);
            if (pulse_full_o) begin
                if (last_rise >= 0)
                    chk(k - last_rise == n, req, "period (R4)", k - last_rise, n);
                last_rise = k;
            end
        end
    endtask

    // Illegal divisor: error flag, no count, no pulses.
    task automatic run_bad(input int n, input bit m);
        do_reset(n, m);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk); #5;
            chk(err_o == 1'b1, "R7", "err flag", int'(err_o), 1);
            chk(count_o == '0, "R7", "count held", int'(count_o), 0);
            chk(pulse_short_o == 1'b0, "R7", "short quiet", int'(pulse_short_o), 0);
            @(posedge clk); #5;
            chk(pulse_full_o == 1'b0, "R7", "full quiet", int'(pulse_full_o), 0);
        end
    endtask

    initial begin
        run_div(2, 1'b0, 12, "R6 modeA", 1'b0);
        run_div(2, 1'b1, 12, "R6 modeB", 1'b0);
        run_div(3, 1'b0, 14, "R6 modeA", 1'b0);
        run_div(7, 1'b1, 30, "R6 modeB", 1'b0);
        run_div(10, 1'b1, 35, "R9", 1'b1);
        run_div(5, 1'b0, 20, "R9", 1'b1);
        for (int i = 0; i < 8; i++) begin
            int n = $urandom_range(2, 300);
            run_div(n, i[0], 2 * n + 5, "R6 random", 1'b0);
        end
        run_div(1 << W, 1'b0, 2 * (1 << W) + 4, "R8 modeA", 1'b0);
        run_div(1 << W, 1'b1, (1 << W) + 4, "R8 modeB", 1'b0);
        run_bad(1, 1'b0);
        run_bad(0, 1'b1);
        run_div(4, 1'b0, 10, "R7 recover", 1'b0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule